// File: doc/BRIEF.md
# Programmable CRC-32 Register Peripheral

A memory-mapped checksum engine on a simple 32-bit register bus with byte strobes. Software loads a 32-bit seed and a 32-bit generator polynomial, clears the engine through a control register, and then feeds payload to the data register. A write to the data register can be a single byte or a full word. The engine folds the whole write into the running CRC in the same clock cycle, shifting the most significant bit out first.

Reading the data register returns the running CRC, optionally bit-reversed. Software can therefore save a partial result, run another stream on the engine, and later resume by loading the saved value as the seed. Input reversal can work per byte, per half-word or across the whole word. Combined with output reversal, this lets the MSB-first engine produce reflected CRC variants such as the common Ethernet/zip CRC-32 and the Castagnoli CRC-32C.

Top module: `crc32_regs`

## Requirements
- R1: After reset, the seed register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0 and the data register reads 0xFFFFFFFF.
- R2: The data register is at byte offset 0x00, control at 0x08, seed at 0x10 and polynomial at 0x14. The seed and polynomial registers update only the bytes whose strobe bit is set (strobe bit k covers data bits 8k+7..8k). Any other offset reads 0.
- R3: A control write (strobe bit 0 set) with bit 0 = 1 loads the seed register into the accumulator. Control bit 0 always reads back 0. Reversal bits written in the same write take effect on the next data write.
- R4: A data write with strobe 4'b1111 folds all 32 bus bits into the CRC, MSB first, in one cycle; the result is readable on the next access. With no write, the CRC holds.
- R5: A data write with strobe 4'b0001 folds only bus bits [7:0] into the CRC, MSB first. Bus bits [31:8] have no effect.
- R6: For word writes, control bits [6:5] choose the input reversal: 00 none, 01 bit order reversed within each byte, 10 reversed within each 16-bit half, 11 reversed across the whole 32-bit word.
- R7: For byte writes, any nonzero value of control bits [6:5] reverses the bit order of the byte before it is folded.
- R8: When control bit 7 is 1, a read of the data register returns the accumulator with its 32 bits reversed. Otherwise the read returns the accumulator as is.
- R9: A data write with any strobe pattern other than 4'b0001 or 4'b1111 leaves the CRC unchanged.
- R10: A CRC read back, then written as the seed and reloaded by a control reset, continues the computation exactly as if the stream had never been interrupted.
- R11: The polynomial is fully programmable. With polynomial 0x1EDC6F41 and reflected operation, the engine yields the CRC-32C check value 0xE3069283 (after a final inversion) for the ASCII string "123456789".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_be | input | 4 | Byte strobes of a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The bench goes after the places where the bit order is easiest to get wrong. It runs three known-answer strings: the unreflected MPEG-2 CRC, and the reflected CRC-32 and CRC-32C, which are built from word writes with whole-word reversal followed by a tail byte with per-byte reversal. A design that swapped the reversal modes, took a byte from the wrong lane or shifted LSB-first would miss these values. Byte writes carry junk in the upper lanes, and odd strobe patterns are sent to the data register; a design that decoded width loosely would fold the junk or the partial words into the CRC. The bench also checks that control bit 0 reads back 0 and that a saved-and-restored partial CRC resumes seamlessly. This catches a reset bit that sticks, or a reload taken from the wrong register.

// File: rtl/crc32_regs.sv
module crc32_regs #(
  parameter int          ADDR_W   = 5,
  parameter logic [31:0] INIT_RST = 32'hFFFFFFFF,
  parameter logic [31:0] POLY_RST = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(8'h14);

  logic [31:0] crc_q, init_q, poly_q;
  logic [1:0]  rev_in_q;
  logic        rev_out_q;

  function automatic logic [31:0] swizzle(input logic [31:0] v, input logic [1:0] m);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      case (m)
        2'b01:   r[i] = v[(i & ~7)  | (7  - (i & 7))];
        2'b10:   r[i] = v[(i & ~15) | (15 - (i & 15))];
        2'b11:   r[i] = v[31 - i];
        default: r[i] = v[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] fold(input logic [31:0] c, input logic [31:0] p, input int n);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 32; i++)
      if (i < n) r = r[31] ? ((r << 1) ^ p) : (r << 1);
    return r;
  endfunction

  wire hit_data = bus_wr && (bus_addr == A_DATA);
  wire hit_ctrl = bus_wr && (bus_addr == A_CTRL) && bus_be[0];
  wire word_wr  = hit_data && (bus_be == 4'b1111);
  wire byte_wr  = hit_data && (bus_be == 4'b0001);

  wire [7:0]  byte_in  = (rev_in_q != 2'b00) ? swizzle({24'h0, bus_wdata[7:0]}, 2'b01) : bus_wdata[7:0];
  wire [31:0] crc_word = fold(crc_q ^ swizzle(bus_wdata, rev_in_q), poly_q, 32);
  wire [31:0] crc_byte = fold(crc_q ^ {byte_in, 24'h0}, poly_q, 8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q     <= INIT_RST;
      init_q    <= INIT_RST;
      poly_q    <= POLY_RST;
      rev_in_q  <= 2'b00;
      rev_out_q <= 1'b0;
    end else begin
      if (word_wr) crc_q <= crc_word;
      else if (byte_wr) crc_q <= crc_byte;
      else if (hit_ctrl && bus_wdata[0]) crc_q <= init_q;
      if (hit_ctrl) begin
        rev_in_q  <= bus_wdata[6:5];
        rev_out_q <= bus_wdata[7];
      end
      for (int b = 0; b < 4; b++) begin
        if (bus_wr && bus_addr == A_SEED && bus_be[b]) init_q[8*b +: 8] <= bus_wdata[8*b +: 8];
        if (bus_wr && bus_addr == A_POLY && bus_be[b]) poly_q[8*b +: 8] <= bus_wdata[8*b +: 8];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rev_out_q ? swizzle(crc_q, 2'b11) : crc_q;
      A_CTRL:  bus_rdata = {24'h0, rev_out_q, rev_in_q, 5'b00000};
      A_SEED:  bus_rdata = init_q;
      A_POLY:  bus_rdata = poly_q;
      default: bus_rdata = 32'h0;
    endcase
  end
endmodule

module crc32_regs_chk #(parameter int ADDR_W = 5) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       crc_q,
  input logic [31:0]       init_q,
  input logic [31:0]       poly_q
);
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(8'h08) && bus_be[0] && bus_wdata[0] |=> crc_q == $past(init_q));
  p_ctrl_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_W'(8'h08) |-> bus_rdata[0] == 1'b0 && bus_rdata[31:8] == 24'h0);
  p_odd_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(8'h00) && bus_be != 4'b1111 && bus_be != 4'b0001 |=> $stable(crc_q));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(crc_q));
  p_poly_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(8'h14) && bus_be == 4'b1111 |=> poly_q == $past(bus_wdata));
  p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_W'(8'h04) |-> bus_rdata == 32'h0);
endmodule

bind crc32_regs crc32_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .crc_q(crc_q), .init_q(init_q), .poly_q(poly_q)
);

// File: tb/crc32_regs_test.sv
`timescale 1ns/1ps
module crc32_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = 5'h0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  int checks = 0;
  int errors = 0;
  logic [31:0] mcrc;

  always #2.5 clk = ~clk;

  crc32_regs uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [7:0] r8(input logic [7:0] x);
    return {x[0], x[1], x[2], x[3], x[4], x[5], x[6], x[7]};
  endfunction
  function automatic logic [15:0] r16(input logic [15:0] x);
    return {r8(x[7:0]), r8(x[15:8])};
  endfunction
  function automatic logic [31:0] r32(input logic [31:0] x);
    return {r16(x[15:0]), r16(x[31:16])};
  endfunction
  function automatic logic [31:0] lfsr(input logic [31:0] c, input logic [31:0] d,
                                       input int n, input logic [31:0] p);
    logic [31:0] s;
    logic fb;
    s = c;
    for (int k = n - 1; k >= 0; k--) begin
      fb = s[31] ^ d[k];
      s = s << 1;
      if (fb) s = s ^ p;
    end
    return s;
  endfunction
  function automatic logic [31:0] m_word(input logic [31:0] c, input logic [31:0] d,
                                         input logic [1:0] m, input logic [31:0] p);
    logic [31:0] v;
    case (m)
      2'b01:   v = {r8(d[31:24]), r8(d[23:16]), r8(d[15:8]), r8(d[7:0])};
      2'b10:   v = {r16(d[31:16]), r16(d[15:0])};
      2'b11:   v = r32(d);
      default: v = d;
    endcase
    return lfsr(c, v, 32, p);
  endfunction
  function automatic logic [31:0] m_byte(input logic [31:0] c, input logic [7:0] d,
                                         input logic [1:0] m, input logic [31:0] p);
    return lfsr(c, {24'h0, (m != 2'b00) ? r8(d) : d}, 8, p);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic restart(input logic [31:0] seed, input logic [31:0] poly, input logic [7:0] ctl);
    wr(5'h10, seed, 4'hF);
    wr(5'h14, poly, 4'hF);
    wr(5'h08, {24'h0, ctl | 8'h01}, 4'h1);
    mcrc = seed;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(5'h10, v); check("R1 seed", v, 32'hFFFFFFFF);
    rd(5'h14, v); check("R1 poly", v, 32'h04C11DB7);
    rd(5'h08, v); check("R1 ctrl", v, 32'h0);
    rd(5'h00, v); check("R1 data", v, 32'hFFFFFFFF);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(5'h10, 32'h12345678, 4'hF);
    wr(5'h10, 32'hAABBCCDD, 4'b0010);
    rd(5'h10, v); check("R2 seed byte strobe", v, 32'h1234CC78);
    wr(5'h14, 32'h0F0F0F0F, 4'b1001);
    rd(5'h14, v); check("R2 poly byte strobe", v, 32'h0FC11D0F);
    rd(5'h04, v); check("R2 unmapped", v, 32'h0);
    rd(5'h18, v); check("R2 unmapped high", v, 32'h0);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(5'h10, 32'hCAFEF00D, 4'hF);
    wr(5'h08, 32'hFFFFFF61, 4'h1);
    rd(5'h08, v); check("R3 ctrl readback", v, 32'h60);
    rd(5'h00, v); check("R3 reload seed", v, 32'hCAFEF00D);
    wr(5'h08, 32'h0, 4'h1);
    rd(5'h00, v); check("R3 no reload without bit0", v, 32'hCAFEF00D);
  endtask

  task automatic t_mpeg;
    logic [31:0] v;
    restart(32'hFFFFFFFF, 32'h04C11DB7, 8'h00);
    for (int i = 0; i < 9; i++) wr(5'h00, 32'hABCDEF00 | (32'h31 + 32'(i)), 4'b0001);
    rd(5'h00, v); check("R5 byte writes MPEG-2 check value", v, 32'h0376E6E7);
  endtask

  task automatic t_word;
    logic [31:0] v;
    logic [31:0] pats [4] = '{32'h00000000, 32'hFFFFFFFF, 32'h80000001, 32'hDEADBEEF};
    restart(32'h0, 32'h04C11DB7, 8'h00);
    for (int i = 0; i < 4; i++) begin
      wr(5'h00, pats[i], 4'hF);
      mcrc = m_word(mcrc, pats[i], 2'b00, 32'h04C11DB7);
      rd(5'h00, v); check("R4 word fold", v, mcrc);
    end
    repeat (3) @(negedge clk);
    rd(5'h00, v); check("R4 hold when idle", v, mcrc);
  endtask

  task automatic t_modes;
    logic [31:0] v;
    for (int m = 1; m < 4; m++) begin
      restart(32'h5A5A0000, 32'h04C11DB7, 8'(m << 5));
      wr(5'h00, 32'h01234567, 4'hF);
      mcrc = m_word(mcrc, 32'h01234567, 2'(m), 32'h04C11DB7);
      wr(5'h00, 32'hF00F1234, 4'hF);
      mcrc = m_word(mcrc, 32'hF00F1234, 2'(m), 32'h04C11DB7);
      rd(5'h00, v); check("R6 input reversal mode", v, mcrc);
    end
  endtask

  task automatic t_byte_rev;
    logic [31:0] v;
    restart(32'h13579BDF, 32'h04C11DB7, 8'h40);
    wr(5'h00, 32'h000000C1, 4'b0001);
    mcrc = m_byte(mcrc, 8'hC1, 2'b10, 32'h04C11DB7);
    rd(5'h00, v); check("R7 byte reversal under mode 10", v, mcrc);
  endtask

  task automatic t_reflected(input logic [31:0] poly, input logic [31:0] exp, input string req);
    logic [31:0] v;
    restart(32'hFFFFFFFF, poly, 8'hE0);
    wr(5'h00, 32'h34333231, 4'hF);
    wr(5'h00, 32'h38373635, 4'hF);
    wr(5'h08, 32'hA0, 4'h1);
    wr(5'h00, 32'h39, 4'b0001);
    rd(5'h00, v); check(req, v ^ 32'hFFFFFFFF, exp);
  endtask

  task automatic t_outrev;
    logic [31:0] v;
    restart(32'h00000001, 32'h04C11DB7, 8'h80);
    rd(5'h00, v); check("R8 output reversal", v, 32'h80000000);
    wr(5'h08, 32'h0, 4'h1);
    rd(5'h00, v); check("R8 output plain", v, 32'h00000001);
  endtask

  task automatic t_strobe;
    logic [31:0] v;
    restart(32'h2468ACE0, 32'h04C11DB7, 8'h00);
    wr(5'h00, 32'h11223344, 4'b0011);
    wr(5'h00, 32'h11223344, 4'b0010);
    wr(5'h00, 32'h11223344, 4'b0000);
    wr(5'h00, 32'h11223344, 4'b1110);
    rd(5'h00, v); check("R9 odd strobes ignored", v, 32'h2468ACE0);
  endtask

  task automatic t_restore;
    logic [31:0] v, saved, full;
    full = 32'hFFFFFFFF;
    for (int i = 0; i < 4; i++) full = m_word(full, 32'h10203040 * (i + 1), 2'b00, 32'h04C11DB7);
    restart(32'hFFFFFFFF, 32'h04C11DB7, 8'h00);
    for (int i = 0; i < 2; i++) wr(5'h00, 32'h10203040 * (i + 1), 4'hF);
    rd(5'h00, saved);
    restart(32'hDEADBEEF, 32'h04C11DB7, 8'h00);
    wr(5'h00, 32'h77777777, 4'hF);
    restart(saved, 32'h04C11DB7, 8'h00);
    for (int i = 2; i < 4; i++) wr(5'h00, 32'h10203040 * (i + 1), 4'hF);
    rd(5'h00, v); check("R10 save and restore", v, full);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_ctrl();
    t_mpeg();
    t_word();
    t_modes();
    t_byte_rev();
    t_reflected(32'h04C11DB7, 32'hCBF43926, "R6 R7 R8 reflected CRC-32");
    t_reflected(32'h1EDC6F41, 32'hE3069283, "R11 CRC-32C");
    t_outrev();
    t_strobe();
    t_restore();
    finish_run();
  end
endmodule